// File: doc/BRIEF.md
# Configurable SPI Bus Master

This block is a full-duplex synchronous serial master for an SPI bus. A parallel request supplies one word to send, the index of the target to talk to, the clock polarity and phase, the bit order and a divider value. The block pulls the chosen active-low select line, runs the serial clock and shifts the word out on MOSI. In the same serial clock periods it shifts the target's word in from MISO. When the exchange is finished it raises a one-cycle completion pulse and presents the received word.

The master and target shift registers form a ring, so after one full word the two sides have swapped contents. Every transfer sends and receives. For a target that accepts no commands, the caller sets a fill flag and the block shifts a programmable filler word in place of the request word; the usual filler is 0x00. For a target that returns nothing, the caller simply discards the received word. All request fields are captured when a request is accepted, so the caller may change its inputs while a transfer is running.

Top module: `spi_xfer_master`

## Requirements
- R1: After a transfer, `rx_word` equals the word the target held when its select was asserted, and the target has received the transmitted word.
- R2: From the accepting clock edge until half a serial period after the last SCLK edge, exactly the select bit `cs_n[req_target]` is low. At all other times every select bit is high.
- R3: SCLK rests at the polarity of the most recent accepted request, or at 0 after reset. During a transfer it toggles 2*WORD_W times. The first toggle comes h system clocks after acceptance and the toggles are h clocks apart, where h is half the divider.
- R4: With phase 0, MOSI carries the first bit from the moment the select is asserted, and both sides sample on the first (leading) edge of each bit. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R5: `req_lsb_first`=0 sends bit WORD_W-1 first and `req_lsb_first`=1 sends bit 0 first. The received word is assembled in the same order.
- R6: When `req_send_fill`=1, the word shifted out is `fill_word` and not `req_tx_word`.
- R7: `busy` is high from the cycle after acceptance to the cycle before `done`. `done` is a one-cycle pulse that comes (2*WORD_W+1)*h+2 clocks after the accepting edge. `rx_word` is valid while `done` is high.
- R8: A request presented while `busy` is high is ignored: no second transfer starts and the running transfer is not disturbed.
- R9: Divider, target, mode, order and data are captured at acceptance. Changing these inputs mid-transfer has no effect on that transfer.
- R10: Bit 0 of `clk_div` is ignored, so odd values round down. Values below 2 behave as 2, giving h = 1.
- R11: In reset, every select bit is high, SCLK is 0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start request, taken only while idle |
| req_tx_word | input | WORD_W | Word to send |
| req_send_fill | input | 1 | Send `fill_word` instead of `req_tx_word` |
| req_target | input | TGT_W | Index of the target to select |
| req_lsb_first | input | 1 | Bit order: 1 = bit 0 first |
| req_cpol | input | 1 | SCLK idle level |
| req_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| clk_div | input | DIV_W | System clocks per serial period (even, at least 2) |
| fill_word | input | WORD_W | Filler word for one-directional targets |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | WORD_W | Received word, valid with `done` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target (asynchronous) |
| cs_n | output | NUM_TGT | Active-low target selects |

## Verification
The bench goes after phase handling. A master that drives the first bit one edge late under phase 0 would shift every received bit by one position, and the target model would catch the swapped words. It runs the smallest divider (h = 1), where the two-flop MISO synchronizer is as slow as a whole half period. A design that sampled the synchronized line at the SCLK edge would capture the previous bit. It also changes polarity between transfers, where a stray edge at select assertion would misalign the target. It pulses a request with different settings in the middle of a transfer. A design that did not latch its fields, or did not ignore requests while busy, would change SCLK timing or the selected line, and the per-cycle comparison would show it.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
// Shared types for the SPI transfer master.
// Assumes: nothing beyond standard SystemVerilog packages.
package spi_xfer_pkg;

    // Sequencer phases of one transfer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_FLUSH
    } xfer_state_t;

    // Per-transfer settings captured at acceptance (R9).
    typedef struct packed {
        logic cpha;
        logic lsb_first;
    } xfer_mode_t;

endpackage

// File: rtl/spi_halfper_timer.sv
`timescale 1ns/1ps
// Half serial period timer: pulses tick once every div/2 system clocks while run is high.
// Assumes: div_i is stable during a transfer; bit 0 ignored, values below 2 act as 2 (R10).
module spi_halfper_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_w;

    // Derive the half period in system clocks, clamped to at least one.
    always_comb begin
        half_w = div_i >> 1;
        if (half_w == '0) half_w = DIV_W'(1);
    end

    assign tick = run && (cnt_q == half_w - DIV_W'(1));

    // Count system clocks inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart || !run)  cnt_q <= '0;
        else if (tick)             cnt_q <= '0;
        else                       cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/spi_miso_sync.sv
`timescale 1ns/1ps
// Synchronizer chain for the asynchronous MISO input.
// Assumes: STAGES >= 1; adds STAGES clocks of latency that the sequencer accounts for.
module spi_miso_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= 1'b0;
                else        chain_q[s] <= (s == 0) ? din : chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_word_shifter.sv
`timescale 1ns/1ps
// Transmit and receive shift registers with runtime bit order (R5).
// Assumes: tx_shift and rx_shift never fire in the same cycle as load.
module spi_word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              lsb_first,
    input  logic              tx_shift,
    input  logic              rx_shift,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    assign tx_bit  = lsb_first ? tx_q[0] : tx_q[WORD_W-1];
    assign rx_word = rx_q;

    // Outgoing word: load at start, advance one bit per drive edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (load)     tx_q <= load_word;
        else if (tx_shift) tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
    end

    // Incoming word: cleared at start, one synchronized bit per sample.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (load)     rx_q <= '0;
        else if (rx_shift) rx_q <= lsb_first ? {rx_bit, rx_q[WORD_W-1:1]}
                                             : {rx_q[WORD_W-2:0], rx_bit};
    end
endmodule

// File: rtl/spi_xfer_master.sv
`timescale 1ns/1ps
// SPI transfer master: one word exchanged per request with a selected target,
// in any of the four polarity/phase modes and either bit order.
// Assumes: miso is asynchronous; clk_div even and >= 2 (others are clamped, R10).
module spi_xfer_master #(
    parameter int WORD_W  = 8,
    parameter int NUM_TGT = 4,
    parameter int DIV_W   = 8,
    parameter int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_tx_word,
    input  logic              req_send_fill,
    input  logic [TGT_W-1:0]  req_target,
    input  logic              req_lsb_first,
    input  logic              req_cpol,
    input  logic              req_cpha,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [WORD_W-1:0] fill_word,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_TGT-1:0] cs_n
);
    import spi_xfer_pkg::*;

    localparam int NUM_EDGES = 2 * WORD_W;
    localparam int EDGE_W    = $clog2(NUM_EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(NUM_EDGES - 1);
    localparam int SYNC_STAGES = 2;

    xfer_state_t        state_q;
    xfer_mode_t         mode_q;
    logic [DIV_W-1:0]   div_q;
    logic [EDGE_W-1:0]  edge_q;
    logic               sclk_q;
    logic [NUM_TGT-1:0] cs_q;
    logic [NUM_TGT-1:0] sel_n;
    logic [SYNC_STAGES-1:0] pend_q;
    logic               flush_q;
    logic               done_q;

    logic accept, run, tick, edge_now, leading, sample_edge, drive_edge;
    logic miso_s;

    assign accept   = (state_q == ST_IDLE) && req_valid;              // R8
    assign run      = (state_q == ST_SETUP) || (state_q == ST_SHIFT) || (state_q == ST_HOLD);
    assign edge_now = tick && ((state_q == ST_SETUP) || (state_q == ST_SHIFT));
    assign leading  = ~edge_q[0];
    assign sample_edge = edge_now && (leading ^ mode_q.cpha);         // R4
    assign drive_edge  = edge_now && !(leading ^ mode_q.cpha)
                         && (edge_q != '0) && (edge_q != LAST_EDGE);

    // Select mask for the requested target (R2).
    always_comb begin
        sel_n = '1;
        for (int i = 0; i < NUM_TGT; i++)
            if (req_target == TGT_W'(i)) sel_n[i] = 1'b0;
    end

    spi_halfper_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(accept), .run(run),
        .div_i(div_q), .tick(tick)
    );

    spi_miso_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(miso), .dout(miso_s)
    );

    spi_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .load_word(req_send_fill ? fill_word : req_tx_word),          // R6
        .lsb_first(mode_q.lsb_first), .tx_shift(drive_edge),
        .rx_shift(pend_q[SYNC_STAGES-1]), .rx_bit(miso_s),
        .tx_bit(mosi), .rx_word(rx_word)
    );

    // Delay each sample strobe by the synchronizer depth.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= {pend_q[SYNC_STAGES-2:0], sample_edge};
    end

    // Transfer sequencer: select setup, edge train, select hold, flush, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            div_q   <= '0;
            edge_q  <= '0;
            sclk_q  <= 1'b0;                                          // R11
            cs_q    <= '1;
            flush_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin                           // R9 capture
                    mode_q  <= '{cpha: req_cpha, lsb_first: req_lsb_first};
                    div_q   <= clk_div;
                    cs_q    <= sel_n;
                    sclk_q  <= req_cpol;                              // R3 idle level
                    edge_q  <= '0;
                    state_q <= ST_SETUP;
                end
                ST_SETUP: if (tick) begin
                    sclk_q  <= ~sclk_q;
                    edge_q  <= EDGE_W'(1);
                    state_q <= ST_SHIFT;
                end
                ST_SHIFT: if (tick) begin
                    sclk_q <= ~sclk_q;
                    if (edge_q == LAST_EDGE) state_q <= ST_HOLD;
                    else                     edge_q  <= edge_q + EDGE_W'(1);
                end
                ST_HOLD: if (tick) begin
                    cs_q    <= '1;
                    flush_q <= 1'b0;
                    state_q <= ST_FLUSH;
                end
                ST_FLUSH: begin
                    if (flush_q) begin
                        done_q  <= 1'b1;                              // R7
                        state_q <= ST_IDLE;
                    end else begin
                        flush_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign sclk = sclk_q;
    assign cs_n = cs_q;
endmodule

// File: rtl/spi_xfer_master_checker.sv
`timescale 1ns/1ps
// Protocol checker for spi_xfer_master, attached by bind.
// Assumes: synchronous active-low reset on the same clock.
module spi_xfer_master_checker #(
    parameter int NUM_TGT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               sclk,
    input logic [NUM_TGT-1:0] cs_n
);
    a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_busy_ends_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r3_sclk_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(sclk));
endmodule

bind spi_xfer_master spi_xfer_master_checker #(.NUM_TGT(NUM_TGT)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/spi_xfer_master_bench.sv
`timescale 1ns/1ps
// Bench: behavioural target on the bus plus a per-cycle timing model.
module spi_xfer_master_bench;
    localparam int W  = 8;
    localparam int NT = 4;
    localparam int DW = 8;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [W-1:0] req_tx_word = '0;
    logic req_send_fill = 1'b0;
    logic [TW-1:0] req_target = '0;
    logic req_lsb_first = 1'b0, req_cpol = 1'b0, req_cpha = 1'b0;
    logic [DW-1:0] clk_div = 8'd4;
    logic [W-1:0] fill_word = 8'h00;
    logic busy, done, sclk, mosi;
    logic miso = 1'b0;
    logic [W-1:0] rx_word;
    logic [NT-1:0] cs_n;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    spi_xfer_master #(.WORD_W(W), .NUM_TGT(NT), .DIV_W(DW)) u_spi_xfer_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tx_word(req_tx_word),
        .req_send_fill(req_send_fill), .req_target(req_target),
        .req_lsb_first(req_lsb_first), .req_cpol(req_cpol), .req_cpha(req_cpha),
        .clk_div(clk_div), .fill_word(fill_word), .busy(busy), .done(done),
        .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int half_of(input int d);
        return ((d >> 1) < 1) ? 1 : (d >> 1);
    endfunction

    // ---------------- behavioural target ----------------
    bit cfg_cpol, cfg_cpha, cfg_lsb;
    int cfg_tgt = 0;
    logic [W-1:0] slave_word = '0, t_in = '0;
    int t_samples = 0;
    logic tcs_prev = 1'b1, sclk_prev = 1'b0;
    wire tcs = cs_n[cfg_tgt];

    function automatic logic bit_at(input logic [W-1:0] w, input int j, input bit lsb);
        return lsb ? w[j] : w[W-1-j];
    endfunction

    always @(tcs or sclk) begin
        if (tcs_prev === 1'b1 && tcs === 1'b0) begin
            t_in = '0;
            t_samples = 0;
            miso = bit_at(slave_word, 0, cfg_lsb);
        end else if (tcs === 1'b0 && sclk !== sclk_prev) begin
            if ((sclk != cfg_cpol) ^ cfg_cpha) begin
                t_in = cfg_lsb ? {mosi, t_in[W-1:1]} : {t_in[W-2:0], mosi};
                t_samples++;
            end else if (t_samples < W) begin
                miso = bit_at(slave_word, t_samples, cfg_lsb);
            end
        end
        tcs_prev = tcs;
        sclk_prev = sclk;
    end

    // ---------------- per-cycle timing model ----------------
    bit act = 0, cpol_last = 0;
    int n = 0, h_m = 1, tgt_m = 0;
    function automatic int end_n(input int h);
        return (2*W + 1) * h + 2;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            act = 0; cpol_last = 0;
        end else if ((!act || n == end_n(h_m)) && req_valid) begin
            act = 1; n = 0; h_m = half_of(int'(clk_div));
            tgt_m = int'(req_target); cpol_last = req_cpol;
        end else if (act) begin
            if (n == end_n(h_m)) act = 0;
            else n++;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            logic e_sclk, e_busy, e_done;
            logic [NT-1:0] e_cs;
            int tog;
            if (!act) begin
                e_sclk = cpol_last; e_cs = '1; e_busy = 0; e_done = 0;
            end else begin
                tog = n / h_m;
                if (tog > 2*W) tog = 2*W;
                e_sclk = cpol_last ^ tog[0];
                e_cs = (n < (2*W+1)*h_m) ? ~(NT'(1) << tgt_m) : '1;
                e_busy = (n < end_n(h_m));
                e_done = (n == end_n(h_m));
            end
            chk(sclk === e_sclk, "R3", "sclk per cycle", sclk, e_sclk);
            chk(cs_n === e_cs,   "R2", "cs_n per cycle", cs_n, e_cs);
            chk(busy === e_busy, "R7", "busy per cycle", busy, e_busy);
            chk(done === e_done, "R7", "done per cycle", done, e_done);
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_xfer(input logic [W-1:0] mw, input logic [W-1:0] sw, input int tgt,
                           input bit lsb, input bit cpol, input bit cpha, input int div,
                           input bit fill, input bit disturb);
        int cnt = 0;
        int exp_lat;
        logic [W-1:0] exp_in;
        @(negedge clk);
        cfg_tgt = tgt; cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb = lsb;
        slave_word = sw;
        req_tx_word = mw; req_target = TW'(tgt); req_lsb_first = lsb;
        req_cpol = cpol; req_cpha = cpha; clk_div = DW'(div); req_send_fill = fill;
        req_valid = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) req_valid = 1'b0;
            if (disturb && cnt == 5) begin
                req_valid = 1'b1; req_target = TW'(tgt ^ 1); clk_div = 8'd2;
                req_cpol = !cpol; req_cpha = !cpha; req_lsb_first = !lsb;
                req_tx_word = ~mw;
            end
            if (disturb && cnt == 7) req_valid = 1'b0;
        end while (done !== 1'b1 && cnt < 5000);
        exp_lat = end_n(half_of(div));
        exp_in = fill ? fill_word : mw;
        chk(rx_word === sw, "R1 R4 R5", "received word", rx_word, sw);
        chk(t_in === exp_in, fill ? "R6" : "R1 R4 R5", "word seen by target", t_in, exp_in);
        chk(cnt - 1 == exp_lat, disturb ? "R9 R10" : "R3 R7 R10", "accept-to-done cycles",
            cnt - 1, exp_lat);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && (&cs_n), disturb ? "R8" : "R7", "idle after done",
            {busy, cs_n}, {1'b0, {NT{1'b1}}});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n === '1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R11", "reset state", {cs_n, sclk, busy, done}, {{NT{1'b1}}, 3'b000});
        rst_n = 1'b1;
        cmp_on = 1;
        for (int m = 0; m < 8; m++)
            do_xfer(8'hA0 + 8'(m * 17), 8'h3C ^ 8'(m * 29), m % NT,
                    m[0], m[1], m[2], 2 + 2 * (m % 4), 1'b0, 1'b0);
        do_xfer(8'h81, 8'h7E, 2, 1'b0, 1'b1, 1'b1, 2, 1'b0, 1'b0);   // R4 at h=1
        do_xfer(8'h01, 8'hF0, 1, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);   // R10 div 0
        do_xfer(8'hC3, 8'h5A, 3, 1'b0, 1'b0, 1'b1, 5, 1'b0, 1'b0);   // R10 odd div
        do_xfer(8'h99, 8'h00, 0, 1'b0, 1'b0, 1'b0, 4, 1'b1, 1'b0);   // R6 fill 0x00
        fill_word = 8'hA5;
        do_xfer(8'h12, 8'hE7, 2, 1'b1, 1'b1, 1'b0, 6, 1'b1, 1'b0);   // R6 fill A5
        fill_word = 8'h00;
        do_xfer(8'h6D, 8'hB2, 1, 1'b0, 1'b1, 1'b0, 8, 1'b0, 1'b1);   // R8 R9
        do_xfer(8'h2B, 8'h94, 3, 1'b1, 1'b0, 1'b1, 4, 1'b0, 1'b1);   // R8 R9
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule